// File: doc/BRIEF.md
# PCM Serial Port with Frame-Sync Classification

This block moves one 8-bit PCM sample out and one sample in during each frame of a serial voice link. All of its logic runs on a fast system clock. The bit clock, the frame strobe and the receive line are treated as asynchronous inputs: each is resynchronised, and the block finds the bit-clock edges itself. Inputs are sampled on the falling bit-clock edges it finds. Transmit bits change on the rising edges it finds.

The block measures every frame strobe by counting how many falling bit-clock edges see it high. A strobe seen on exactly one edge is short. A strobe seen on two or more edges is long. The measurement of one strobe sets how the line driver behaves in the next frame. The transmit pin is modelled as a data bit plus a separate drive-enable.

After reset or power-down, the driver stays off for two whole frames so that it cannot collide with another talker on a shared bus.

Transmit samples enter through a valid/ready stream with a one-word holding register. `tx_ready` is high while that register is empty. A word is taken when `tx_valid` and `tx_ready` are both high on a clock edge. The upstream side must hold `tx_data` and `tx_valid` steady while `tx_ready` is low. Received samples leave with no back-pressure: `rx_valid` pulses for one clock, and `rx_data` keeps its value until the next word arrives.

Top module: `pcm_sync_port`

## Requirements
- R1: After reset, `tx_oe` is 0, `rx_valid` is 0, `tx_ready` is 1 and `sync_long` is 0.
- R2: A strobe seen high on only one bit-clock falling edge is classed as short, so `sync_long` reads 0 at the start of the following frame.
- R3: A strobe seen high on two or more consecutive falling edges is classed as long, so `sync_long` reads 1 at the start of the following frame.
- R4: A frame begins at the first falling edge that sees the strobe high. The word goes out MSB first: bit 7 appears on the first rising edge after the frame begins, and each later rising edge presents the next lower bit.
- R5: With the short class in force, `tx_oe` rises with bit 7 and falls on the falling edge that splits the LSB period, which is the eighth falling edge after the frame begins.
- R6: With the long class in force, `tx_oe` is also high whenever the strobe is high. The driver therefore releases at whichever comes later: the middle of the LSB or the fall of the strobe.
- R7: The class in force during a frame's strobe comes from the previous strobe. Reset and power-down select short. A long strobe arriving while the short class is in force does not enable the driver before bit 7.
- R8: `rx_line` is sampled on the first through eighth falling edges after the frame begins, MSB first. `rx_valid` then pulses for one clock with the word on `rx_data`, which holds until the next word.
- R9: `tx_ready` equals "holding register empty". Each driven frame takes the held word when it begins and empties the register. If no word is held, the frame sends 0xFF.
- R10: While `pwr_down` is high, `tx_oe` is 0 and the class returns to short. The first two frames after power-down or reset keep `tx_oe` at 0 throughout, do not take the held word, and still receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Power-down request, synchronous to `clk` |
| bclk | input | 1 | Serial bit clock (asynchronous) |
| fsync | input | 1 | Frame strobe (asynchronous) |
| rx_line | input | 1 | Serial receive data (asynchronous) |
| tx_data | input | 8 | Transmit word offered upstream |
| tx_valid | input | 1 | Transmit word valid |
| tx_ready | output | 1 | Holding register empty |
| tx_bit | output | 1 | Serial transmit bit |
| tx_oe | output | 1 | Drive-enable for the transmit pin |
| rx_data | output | 8 | Last received word |
| rx_valid | output | 1 | One-clock pulse when `rx_data` updates |
| sync_long | output | 1 | Class in force: 1 long, 0 short |

## Verification
A strobe that is measured wrongly does not show in the frame where it happens. It shows one frame later, on `sync_long` and on `tx_oe` during the next strobe's opening bit period, which is at most one frame away. A bit counter that is off by one shows within the same frame: as a shifted `tx_bit` pattern, as a `tx_oe` fall in the wrong half-period, or as a rotated `rx_data`. A quiet counter that is stuck either keeps `tx_oe` low on the third frame after power-down or lets it rise on the first or second frame. Either fault is visible within three frames.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/pcm_edge_sync.sv
// Resynchronises the bit clock, strobe and receive line with matching delay,
// then marks bit-clock edges for one system clock.
module pcm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic fsync,
  input  logic rx_line,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic fs_lvl,
  output logic rx_lvl
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] bclk_q, fs_q, rx_q;
  logic         bclk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q    <= '0;
      fs_q      <= '0;
      rx_q      <= '0;
      bclk_last <= 1'b0;
    end else begin
      bclk_q    <= {bclk_q[TOP-1:0], bclk};
      fs_q      <= {fs_q[TOP-1:0], fsync};
      rx_q      <= {rx_q[TOP-1:0], rx_line};
      bclk_last <= bclk_q[TOP];
    end
  end

  assign bclk_rise = bclk_q[TOP] & ~bclk_last;
  assign bclk_fall = ~bclk_q[TOP] & bclk_last;
  assign fs_lvl    = fs_q[TOP];
  assign rx_lvl    = rx_q[TOP];
endmodule

// File: rtl/pcm_frame_ctl.sv
// Detects frame starts, measures strobe width, holds the class in force and
// counts quiet frames after power-down.
module pcm_frame_ctl
  import pcm_port_pkg::*;
#(
  parameter int QUIET_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_down,
  input  logic       bclk_fall,
  input  logic       fs_lvl,
  output logic       frame_start,
  output logic       quiet_pending,
  output logic       muted,
  output sync_mode_e sync_mode
);
  localparam int QW = $clog2(QUIET_FRAMES + 1);

  logic          fs_prev, measuring, seen_two, muted_q;
  logic [QW-1:0] quiet_q;
  sync_mode_e    mode_q;

  assign frame_start   = bclk_fall & fs_lvl & ~fs_prev & ~pwr_down;
  assign quiet_pending = (quiet_q != '0);
  assign muted         = muted_q | quiet_pending;
  assign sync_mode     = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev   <= 1'b1;
      measuring <= 1'b0;
      seen_two  <= 1'b0;
      muted_q   <= 1'b1;
      quiet_q   <= QW'(QUIET_FRAMES);
      mode_q    <= MODE_SHORT;
    end else if (pwr_down) begin
      fs_prev   <= 1'b1;
      measuring <= 1'b0;
      seen_two  <= 1'b0;
      muted_q   <= 1'b1;
      quiet_q   <= QW'(QUIET_FRAMES);
      mode_q    <= MODE_SHORT;
    end else if (bclk_fall) begin
      fs_prev <= fs_lvl;
      if (frame_start) begin
        measuring <= 1'b1;
        seen_two  <= 1'b0;
        muted_q   <= quiet_pending;
        if (quiet_pending) quiet_q <= quiet_q - 1'b1;
      end else if (measuring) begin
        if (fs_lvl) begin
          seen_two <= 1'b1;
        end else begin
          measuring <= 1'b0;
          mode_q    <= seen_two ? MODE_LONG : MODE_SHORT;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_shifter.sv
// Holding register with valid/ready, transmit shifter and receive assembler.
module pcm_shifter #(
  parameter int              WORD_W    = 8,
  parameter logic [WORD_W-1:0] IDLE_WORD = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              bclk_rise,
  input  logic              bclk_fall,
  input  logic              rx_lvl,
  input  logic              frame_start,
  input  logic              take_word,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_bit,
  output logic              drive,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] LAST = CW'(WORD_W);

  logic [WORD_W-1:0] hold_q, tx_sh, rx_sh;
  logic              hold_full, armed;
  logic [CW-1:0]     bit_cnt;

  assign tx_ready = ~hold_full;
  assign tx_bit   = tx_sh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= '0;
      hold_full <= 1'b0;
      tx_sh     <= IDLE_WORD;
      rx_sh     <= '0;
      rx_data   <= '0;
      rx_valid  <= 1'b0;
      armed     <= 1'b0;
      drive     <= 1'b0;
      bit_cnt   <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (tx_valid && !hold_full) begin
        hold_q    <= tx_data;
        hold_full <= 1'b1;
      end
      if (pwr_down) begin
        armed   <= 1'b0;
        drive   <= 1'b0;
        bit_cnt <= '0;
      end else if (frame_start) begin
        armed   <= 1'b1;
        drive   <= 1'b0;
        bit_cnt <= '0;
        if (take_word) begin
          tx_sh <= hold_full ? hold_q : IDLE_WORD;
          if (hold_full) hold_full <= 1'b0;
        end
      end else if (armed && bclk_rise && bit_cnt != LAST) begin
        bit_cnt <= bit_cnt + 1'b1;
        drive   <= 1'b1;
        if (bit_cnt != '0) tx_sh <= {tx_sh[WORD_W-2:0], 1'b1};
      end else if (armed && bclk_fall && bit_cnt != '0) begin
        rx_sh <= {rx_sh[WORD_W-2:0], rx_lvl};
        if (bit_cnt == LAST) begin
          rx_data  <= {rx_sh[WORD_W-2:0], rx_lvl};
          rx_valid <= 1'b1;
          armed    <= 1'b0;
          drive    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_sync_port.sv
module pcm_sync_port
  import pcm_port_pkg::*;
#(
  parameter int                WORD_W       = 8,
  parameter int                SYNC_STAGES  = 2,
  parameter int                QUIET_FRAMES = 2,
  parameter logic [WORD_W-1:0] IDLE_WORD    = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_down,
  input  logic              bclk,
  input  logic              fsync,
  input  logic              rx_line,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic              tx_bit,
  output logic              tx_oe,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              sync_long
);
  logic       bclk_rise, bclk_fall, fs_lvl, rx_lvl;
  logic       frame_start, quiet_pending, muted, drive;
  sync_mode_e sync_mode;

  pcm_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .rx_line(rx_line),
    .bclk_rise(bclk_rise), .bclk_fall(bclk_fall), .fs_lvl(fs_lvl), .rx_lvl(rx_lvl)
  );

  pcm_frame_ctl #(.QUIET_FRAMES(QUIET_FRAMES)) u_frame (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .bclk_fall(bclk_fall),
    .fs_lvl(fs_lvl), .frame_start(frame_start), .quiet_pending(quiet_pending),
    .muted(muted), .sync_mode(sync_mode)
  );

  pcm_shifter #(.WORD_W(WORD_W), .IDLE_WORD(IDLE_WORD)) u_shift (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .bclk_rise(bclk_rise),
    .bclk_fall(bclk_fall), .rx_lvl(rx_lvl), .frame_start(frame_start),
    .take_word(~quiet_pending), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_bit(tx_bit), .drive(drive),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  assign sync_long = (sync_mode == MODE_LONG);
  assign tx_oe     = ~pwr_down & ~muted & (drive | (sync_long & fs_lvl));
endmodule

// File: rtl/pcm_sync_port_chk.sv
module pcm_sync_port_chk #(
  parameter int WORD_W       = 8,
  parameter int QUIET_FRAMES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_down,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              tx_oe,
  input logic [WORD_W-1:0] rx_data,
  input logic              rx_valid,
  input logic              sync_long
);
  localparam int QW = $clog2(QUIET_FRAMES + 1);
  logic [QW-1:0] words_since_pd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        words_since_pd <= '0;
    else if (pwr_down)                                 words_since_pd <= '0;
    else if (rx_valid && words_since_pd < QW'(QUIET_FRAMES)) words_since_pd <= words_since_pd + 1'b1;
  end

  AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R8
  AST_RX_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n) !rx_valid |-> $stable(rx_data)); // R8
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && tx_ready && !pwr_down) |=> !tx_ready); // R9
  AST_QUIET_AFTER_PD: assert property (@(posedge clk) disable iff (!rst_n) (words_since_pd < QW'(QUIET_FRAMES)) |-> !tx_oe); // R10
  AST_PD_CLEARS_CLASS: assert property (@(posedge clk) disable iff (!rst_n) pwr_down |=> !sync_long); // R10
endmodule

bind pcm_sync_port pcm_sync_port_chk #(.WORD_W(WORD_W), .QUIET_FRAMES(QUIET_FRAMES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_oe(tx_oe), .rx_data(rx_data), .rx_valid(rx_valid),
  .sync_long(sync_long)
);

// File: tb/tb_pcm_sync_port.sv
module tb_pcm_sync_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NCYC       = 12;

  logic clk = 1'b0, rst_n = 1'b0, pwr_down = 1'b0;
  logic bclk = 1'b0, fsync = 1'b0, rx_line = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready, tx_bit, tx_oe, rx_valid, sync_long;
  logic [7:0] rx_data;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  bit m_full = 0;
  logic [7:0] m_hold = '0;
  bit prev_muted = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcm_sync_port dut (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .bclk(bclk), .fsync(fsync),
    .rx_line(rx_line), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_bit(tx_bit), .tx_oe(tx_oe), .rx_data(rx_data), .rx_valid(rx_valid),
    .sync_long(sync_long)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // scoreboard monitor for received words
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) check("R8 unexpected rx word", 1, 0);
      else check("R8 rx word", rx_data, exp_q.pop_front());
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic offer(input logic [7:0] b);
    check("R9 tx_ready", tx_ready, !m_full);
    if (tx_ready) begin
      tx_data = b; tx_valid = 1'b1;
      wait_clk(1);
      tx_valid = 1'b0;
      m_full = 1; m_hold = b;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      fsync = 1'b0; bclk = 1'b1; wait_clk(HALF);
      bclk = 1'b0; wait_clk(HALF);
    end
  endtask

  task automatic run_frame(input int w, input bit muted, input bit long_exp, input logic [7:0] rxb);
    logic [7:0] txb;
    bit mh;
    int exp_oe;
    string tag;
    txb = 8'hFF;
    if (!muted) begin
      txb = m_full ? m_hold : 8'hFF;
      m_full = 0;
    end
    exp_q.push_back(rxb);
    tag = muted ? "R10 oe" : (long_exp ? "R6 oe" : "R5 oe");
    for (int c = 0; c < NCYC; c++) begin
      bclk = 1'b1; fsync = (c < w);
      rx_line = (c >= 1 && c <= 8) ? rxb[8-c] : 1'b0;
      wait_clk(5);
      mh = (c == 0) ? prev_muted : muted;
      exp_oe = (!mh && ((c >= 1 && c <= 8) || (long_exp && c < w))) ? 1 : 0;
      if (c == 0) begin
        check("R7 oe at strobe", tx_oe, exp_oe);
        check(long_exp ? "R3 sync_long" : "R2 sync_long", sync_long, long_exp);
      end else check(tag, tx_oe, exp_oe);
      wait_clk(3);
      if (!muted && c >= 1 && c <= 8) check("R4 tx bit", tx_bit, txb[8-c]);
      bclk = 1'b0;
      wait_clk(5);
      exp_oe = (!muted && ((c >= 1 && c <= 7) || (long_exp && c < w))) ? 1 : 0;
      check(tag, tx_oe, exp_oe);
      wait_clk(3);
    end
    prev_muted = muted;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check("watchdog expired", 1, 0);
      report();
    end
  end

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(2);
    check("R1 tx_oe", tx_oe, 0);
    check("R1 rx_valid", rx_valid, 0);
    check("R1 tx_ready", tx_ready, 1);
    check("R1 sync_long", sync_long, 0);
    idle(2);
    offer(8'h3C); run_frame(1, 1, 0, 8'hA1);   // quiet frame 1
    offer(8'hA5); run_frame(1, 1, 0, 8'h5E);   // quiet frame 2
    offer(8'h5A); run_frame(1, 0, 0, 8'hC7);   // sends 3C
    offer(8'h96); run_frame(2, 0, 0, 8'h18);   // long strobe, short class in force
    offer(8'hC3); run_frame(2, 0, 1, 8'hF0);
    offer(8'h0F); run_frame(10, 0, 1, 8'h69); // strobe outlasts the word
    offer(8'h81); run_frame(1, 0, 1, 8'h33);
    run_frame(2, 0, 0, 8'h80);                // nothing held: idle word
    check("R3 sync_long before power-down", sync_long, 1);
    pwr_down = 1'b1;
    wait_clk(6);
    check("R10 oe in power-down", tx_oe, 0);
    check("R10 class cleared", sync_long, 0);
    pwr_down = 1'b0;
    prev_muted = 1;
    idle(2);
    offer(8'hE7); run_frame(2, 1, 0, 8'h01);
    offer(8'h24); run_frame(2, 1, 1, 8'hFE);
    run_frame(1, 0, 1, 8'h4B);                // sends E7
    idle(2);
    check("R8 all words received", exp_q.size(), 0);
    done = 1;
    report();
  end
endmodule